// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home-node side of a directory-based cache coherence scheme. For each memory block it owns, it keeps a directory entry made of a coherence state (Uncached, Shared or Exclusive) and a full presence vector with one bit per node. It also keeps a small backing store that holds the data of each block. Caches send it three kinds of request: read miss, write miss and data write-back. For each one, the controller updates the entry and sends the messages that satisfy the request. Those messages are invalidations to sharers, a fetch or a fetch-and-invalidate to the current owner, and a data reply to the requester.

The controller handles one request at a time, from acceptance to completion. In Idle it accepts a request. For a request that needs no other node, it goes straight to Reply. When a write miss hits a Shared block, it goes to Invalidate scan. That state sends one invalidation per cycle, starting at node 0 and moving upward, and skips the requester. When a request hits an Exclusive block, it goes to Recall. Recall sends a single fetch or fetch-and-invalidate to the owner and then moves to Wait-for-owner. In that state the controller is busy until the owner returns its data. The returned data is written to the backing store and then forwarded in Reply. Reply always returns to Idle.

The transitions of the directory state are named as follows:
- Uncached→Shared on a read miss.
- Uncached→Exclusive on a write miss.
- Shared→Shared on a read miss.
- Shared→Exclusive on a write miss.
- Exclusive→Shared on a read miss, called recall-for-read.
- Exclusive→Exclusive on a write miss, called ownership transfer.
- Exclusive→Uncached on an owner write-back.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset every entry is Uncached with an empty presence vector and zero data. `req_ready` is 1, and `msg_valid` and `busy` are 0.
- R2: A read miss from node P to an Uncached block produces a reply one cycle after acceptance. The reply has `msg_type`=3, is sent to P and carries the stored data. The block becomes Shared with only P present.
- R3: A write miss from P to an Uncached block produces a reply to P with the stored data one cycle after acceptance. The block becomes Exclusive with P as sole owner.
- R4: A read miss from P to a Shared block adds P to the presence vector and replies with the stored data. The block stays Shared.
- R5: A write miss from P to a Shared block sends one invalidation (`msg_type`=0) per cycle, starting the cycle after acceptance, to each present node other than P, in ascending node order. The reply follows in the next cycle. If P was the only sharer, the reply comes at once. The block becomes Exclusive with owner P.
- R6: A read miss from P to an Exclusive block sends a fetch (`msg_type`=1) to the owner the cycle after acceptance. The controller then holds `busy`=1 and `msg_valid`=0 until `owner_wb_valid` arrives. That data is written to the backing store and replied to P one cycle later. The block becomes Shared with the owner and P present.
- R7: A write miss from P to an Exclusive block sends a fetch-and-invalidate (`msg_type`=2) to the owner and waits as in R6. The owner's data is replied to P. The block stays Exclusive with P as owner.
- R8: A write-back (`req_type`=2) from the owner of an Exclusive block writes `req_data` to the backing store and makes the block Uncached with no sharers. No message is sent.
- R9: A write-back from a node that is not the owner, or to a block that is not Exclusive, changes nothing and sends no message. `owner_wb_valid` outside Wait-for-owner is also ignored.
- R10: `req_ready` is 1 only in Idle, and no message is sent in Idle. The request encodings are read miss=0 and write miss=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_type | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_node | input | NID_W | Requesting node |
| req_addr | input | AW | Block index |
| req_data | input | DATA_W | Write-back data |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| owner_wb_valid | input | 1 | Owner's data returned after a recall |
| owner_wb_data | input | DATA_W | Owner's returned data |
| busy | output | 1 | Waiting for owner data |
| msg_valid | output | 1 | Outgoing message present |
| msg_type | output | 2 | 0 invalidate, 1 fetch, 2 fetch-and-invalidate, 3 data reply |
| msg_node | output | NID_W | Destination node |
| msg_addr | output | AW | Block index |
| msg_data | output | DATA_W | Reply data (zero for other types) |

## Verification
A wrong directory state or presence vector stays hidden until the next request to the same block reaches the ports. At that point it shows up as a missing or extra invalidation, a fetch where a plain reply was due, or reply data that does not match. The sequences therefore revisit each block right after every transition, so that a bad entry is exposed within one request. The bench runs a behavioural model of the whole directory and compares the message port on every cycle of every request. Any change in message order, destination or timing is therefore reported in the cycle where it occurs.

// File: rtl/home_dir_pkg.sv
package home_dir_pkg;
    typedef enum logic [1:0] {
        DS_UNC = 2'd0,
        DS_SHR = 2'd1,
        DS_EXC = 2'd2
    } dir_state_e;

    typedef enum logic [1:0] {
        RQ_READ  = 2'd0,
        RQ_WRITE = 2'd1,
        RQ_WBACK = 2'd2
    } req_kind_e;

    typedef enum logic [1:0] {
        MK_INV       = 2'd0,
        MK_FETCH     = 2'd1,
        MK_FETCH_INV = 2'd2,
        MK_REPLY     = 2'd3
    } msg_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_INV    = 3'd1,
        ST_RECALL = 3'd2,
        ST_WAIT   = 3'd3,
        ST_REPLY  = 3'd4
    } ctrl_state_e;
endpackage

// File: rtl/dir_table.sv
module dir_table
    import home_dir_pkg::*;
#(
    parameter int NODES   = 4,
    parameter int ENTRIES = 16,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           rd_addr,
    output dir_state_e              rd_state,
    output logic [NODES-1:0]        rd_sharers,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  dir_state_e              wr_state,
    input  logic [NODES-1:0]        wr_sharers
);
    dir_state_e       st_q [ENTRIES];
    logic [NODES-1:0] sh_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_q[i] <= DS_UNC;
                sh_q[i] <= '0;
            end
        end else if (wr_en) begin
            st_q[wr_addr] <= wr_state;
            sh_q[wr_addr] <= wr_sharers;
        end
    end

    assign rd_state   = st_q[rd_addr];
    assign rd_sharers = sh_q[rd_addr];

    // R3, R5, R7: an Exclusive entry names exactly one owner
    assert_excl_single_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_state == DS_EXC) |-> $onehot(wr_sharers));
    // R8: an Uncached entry has no sharers
    assert_unc_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_state == DS_UNC) |-> (wr_sharers == '0));
    // R4: a Shared entry has at least one sharer
    assert_shr_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_state == DS_SHR) |-> (wr_sharers != '0));
endmodule

// File: rtl/dir_store.sv
module dir_store #(
    parameter int DATA_W  = 32,
    parameter int ENTRIES = 16,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] mem_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/low_bit_pick.sv
module low_bit_pick #(
    parameter int NODES = 4,
    localparam int NID_W = $clog2(NODES)
) (
    input  logic [NODES-1:0] vec,
    output logic             found,
    output logic [NID_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = NID_W'(i);
            end
        end
    end
endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl
    import home_dir_pkg::*;
#(
    parameter int NODES   = 4,
    parameter int ENTRIES = 16,
    parameter int DATA_W  = 32,
    localparam int NID_W  = $clog2(NODES),
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_type,
    input  logic [NID_W-1:0]  req_node,
    input  logic [AW-1:0]     req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ready,
    input  logic              owner_wb_valid,
    input  logic [DATA_W-1:0] owner_wb_data,
    output logic              busy,
    output logic              msg_valid,
    output logic [1:0]        msg_type,
    output logic [NID_W-1:0]  msg_node,
    output logic [AW-1:0]     msg_addr,
    output logic [DATA_W-1:0] msg_data
);
    localparam logic [NODES-1:0] ONE_BIT = {{(NODES-1){1'b0}}, 1'b1};

    ctrl_state_e       state_q, state_d;
    logic [NID_W-1:0]  node_q, owner_q;
    logic [AW-1:0]     addr_q;
    logic              for_read_q;
    logic [NODES-1:0]  pend_q, pend_d;

    dir_state_e        ent_state;
    logic [NODES-1:0]  ent_sharers;
    logic              tbl_we;
    dir_state_e        tbl_wstate;
    logic [NODES-1:0]  tbl_wsharers;

    logic              mem_we;
    logic [AW-1:0]     mem_waddr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    logic              own_found, inv_found;
    logic [NID_W-1:0]  own_idx, inv_idx;
    logic [NODES-1:0]  req_bit, inv_bit;
    logic              accept;

    dir_table #(.NODES(NODES), .ENTRIES(ENTRIES)) u_table (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(req_addr), .rd_state(ent_state), .rd_sharers(ent_sharers),
        .wr_en(tbl_we), .wr_addr(req_addr), .wr_state(tbl_wstate), .wr_sharers(tbl_wsharers)
    );

    dir_store #(.DATA_W(DATA_W), .ENTRIES(ENTRIES)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(addr_q), .rd_data(mem_rdata),
        .wr_en(mem_we), .wr_addr(mem_waddr), .wr_data(mem_wdata)
    );

    low_bit_pick #(.NODES(NODES)) u_owner_pick (
        .vec(ent_sharers), .found(own_found), .idx(own_idx)
    );

    low_bit_pick #(.NODES(NODES)) u_inv_pick (
        .vec(pend_q), .found(inv_found), .idx(inv_idx)
    );

    assign req_bit   = ONE_BIT << req_node;
    assign inv_bit   = ONE_BIT << inv_idx;
    assign req_ready = (state_q == ST_IDLE);
    assign busy      = (state_q == ST_WAIT);
    assign accept    = req_valid && req_ready;

    // Next state, directory update and backing-store write
    always_comb begin
        state_d      = state_q;
        pend_d       = pend_q;
        tbl_we       = 1'b0;
        tbl_wstate   = DS_UNC;
        tbl_wsharers = '0;
        mem_we       = 1'b0;
        mem_waddr    = addr_q;
        mem_wdata    = owner_wb_data;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (req_type)
                        RQ_READ: begin
                            tbl_we       = 1'b1;
                            tbl_wstate   = DS_SHR;
                            if (ent_state == DS_UNC) begin
                                tbl_wsharers = req_bit;
                                state_d      = ST_REPLY;
                            end else begin
                                tbl_wsharers = ent_sharers | req_bit;
                                state_d      = (ent_state == DS_EXC) ? ST_RECALL : ST_REPLY;
                            end
                        end
                        RQ_WRITE: begin
                            tbl_we       = 1'b1;
                            tbl_wstate   = DS_EXC;
                            tbl_wsharers = req_bit;
                            if (ent_state == DS_SHR) begin
                                pend_d  = ent_sharers & ~req_bit;
                                state_d = (pend_d != '0) ? ST_INV : ST_REPLY;
                            end else if (ent_state == DS_EXC) begin
                                state_d = ST_RECALL;
                            end else begin
                                state_d = ST_REPLY;
                            end
                        end
                        RQ_WBACK: begin
                            if (ent_state == DS_EXC && ent_sharers == req_bit) begin
                                tbl_we       = 1'b1;
                                tbl_wstate   = DS_UNC;
                                tbl_wsharers = '0;
                                mem_we       = 1'b1;
                                mem_waddr    = req_addr;
                                mem_wdata    = req_data;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_INV: begin
                pend_d = pend_q & ~inv_bit;
                if (pend_d == '0) state_d = ST_REPLY;
            end
            ST_RECALL: state_d = ST_WAIT;
            ST_WAIT: begin
                if (owner_wb_valid) begin
                    mem_we  = 1'b1;
                    state_d = ST_REPLY;
                end
            end
            ST_REPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register and request latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            node_q     <= '0;
            owner_q    <= '0;
            addr_q     <= '0;
            for_read_q <= 1'b0;
            pend_q     <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            if (accept) begin
                node_q     <= req_node;
                owner_q    <= own_idx;
                addr_q     <= req_addr;
                for_read_q <= (req_type == RQ_READ);
            end
        end
    end

    // Outgoing message
    always_comb begin
        msg_valid = 1'b0;
        msg_type  = MK_REPLY;
        msg_node  = node_q;
        msg_addr  = addr_q;
        msg_data  = '0;
        unique case (state_q)
            ST_INV: begin
                msg_valid = inv_found;
                msg_type  = MK_INV;
                msg_node  = inv_idx;
            end
            ST_RECALL: begin
                msg_valid = 1'b1;
                msg_type  = for_read_q ? MK_FETCH : MK_FETCH_INV;
                msg_node  = owner_q;
            end
            ST_REPLY: begin
                msg_valid = 1'b1;
                msg_type  = MK_REPLY;
                msg_data  = mem_rdata;
            end
            default: ;
        endcase
    end

    // R10: nothing leaves while a request can be taken
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !msg_valid);
    // R6: no request is taken while waiting on the owner
    assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);
    // R5: the requester never receives its own invalidation
    assert_inv_skips_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_type == MK_INV) |-> (msg_node != node_q));
    // R6, R7: a recall is followed by the wait for owner data
    assert_recall_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && (msg_type == MK_FETCH || msg_type == MK_FETCH_INV)) |=> busy);
    // R6: owner data is forwarded in the following cycle
    assert_owner_forward_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && owner_wb_valid) |=> (msg_valid && msg_type == MK_REPLY
                                       && msg_data == $past(owner_wb_data)));
    // R2: a reply ends the request
    assert_reply_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_type == MK_REPLY) |=> req_ready);
endmodule

// File: tb/home_dir_ctrl_bench.sv
`timescale 1ns/1ps
module home_dir_ctrl_bench;
    localparam int NODES = 4, ENTRIES = 16, DATA_W = 32;
    localparam int NID_W = $clog2(NODES), AW = $clog2(ENTRIES);

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_type = '0;
    logic [NID_W-1:0] req_node = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic req_ready;
    logic owner_wb_valid = 1'b0;
    logic [DATA_W-1:0] owner_wb_data = '0;
    logic busy, msg_valid;
    logic [1:0] msg_type;
    logic [NID_W-1:0] msg_node;
    logic [AW-1:0] msg_addr;
    logic [DATA_W-1:0] msg_data;

    int checks = 0, failures = 0;
    bit finished = 1'b0;

    // behavioural model: 0 Uncached, 1 Shared, 2 Exclusive
    int m_st [ENTRIES];
    int m_sh [ENTRIES];
    int m_mem [ENTRIES];

    always #2 clk = ~clk;

    home_dir_ctrl #(.NODES(NODES), .ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_home_dir_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
        .req_node(req_node), .req_addr(req_addr), .req_data(req_data), .req_ready(req_ready),
        .owner_wb_valid(owner_wb_valid), .owner_wb_data(owner_wb_data), .busy(busy),
        .msg_valid(msg_valid), .msg_type(msg_type), .msg_node(msg_node),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    task automatic chk(bit ok, string rq, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // kind: 0 read miss, 1 write miss, 2 write-back
    task automatic run_req(int kind, int node, int addr, int data, int wdelay, int wdata, string rq);
        int et[$];
        int en[$];
        int rdata = m_mem[addr];
        int owner = 0;
        for (int n = 0; n < NODES; n++) if (m_sh[addr][n]) owner = n;
        if (kind == 0) begin
            if (m_st[addr] == 2) begin
                et.push_back(1); en.push_back(owner);
                m_mem[addr] = wdata; rdata = wdata;
            end
            et.push_back(3); en.push_back(node);
            m_sh[addr] = (m_st[addr] == 0) ? (1 << node) : (m_sh[addr] | (1 << node));
            m_st[addr] = 1;
        end else if (kind == 1) begin
            if (m_st[addr] == 1) begin
                for (int n = 0; n < NODES; n++)
                    if (m_sh[addr][n] && n != node) begin et.push_back(0); en.push_back(n); end
            end else if (m_st[addr] == 2) begin
                et.push_back(2); en.push_back(owner);
                m_mem[addr] = wdata; rdata = wdata;
            end
            et.push_back(3); en.push_back(node);
            m_sh[addr] = 1 << node;
            m_st[addr] = 2;
        end else begin
            if (m_st[addr] == 2 && m_sh[addr] == (1 << node)) begin
                m_mem[addr] = data; m_st[addr] = 0; m_sh[addr] = 0;
            end
        end

        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "ready before request", int'(req_ready), 1);
        req_valid = 1'b1; req_type = kind[1:0]; req_node = node[NID_W-1:0];
        req_addr = addr[AW-1:0]; req_data = data;
        @(posedge clk); #1 req_valid = 1'b0;
        foreach (et[i]) begin
            @(negedge clk);
            chk(msg_valid == 1'b1, rq, "msg_valid", int'(msg_valid), 1);
            chk(int'(msg_type) == et[i], rq, "msg_type", int'(msg_type), et[i]);
            chk(int'(msg_node) == en[i], rq, "msg_node", int'(msg_node), en[i]);
            chk(int'(msg_addr) == addr, rq, "msg_addr", int'(msg_addr), addr);
            chk(req_ready == 1'b0, "R10", "ready while active", int'(req_ready), 0);
            if (et[i] == 3) chk(msg_data == rdata, rq, "reply data", int'(msg_data), rdata);
            if (et[i] == 1 || et[i] == 2) begin
                for (int w = 0; w < wdelay; w++) begin
                    @(negedge clk);
                    chk(busy == 1'b1 && msg_valid == 1'b0, "R6", "busy wait",
                        int'({busy, msg_valid}), 2);
                end
                owner_wb_valid = 1'b1; owner_wb_data = wdata;
                @(posedge clk); #1 owner_wb_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk(msg_valid == 1'b0 && req_ready == 1'b1 && busy == 1'b0, rq, "idle after request",
            int'({msg_valid, req_ready, busy}), 2);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < ENTRIES; i++) begin m_st[i] = 0; m_sh[i] = 0; m_mem[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1 && msg_valid == 1'b0 && busy == 1'b0, "R1", "reset outputs",
            int'({req_ready, msg_valid, busy}), 4);

        run_req(0, 1, 3, 0, 0, 0, "R2");          // Uncached read miss
        run_req(0, 2, 3, 0, 0, 0, "R4");          // Shared read miss
        run_req(0, 0, 3, 0, 0, 0, "R4");
        run_req(1, 2, 3, 0, 0, 0, "R5");          // invalidate 0 and 1, skip 2
        run_req(0, 3, 3, 0, 3, 32'hA5A5, "R6");   // recall-for-read from owner 2
        run_req(1, 0, 3, 0, 0, 0, "R5");          // invalidate 2 and 3
        run_req(1, 1, 3, 0, 1, 32'h1234, "R7");   // ownership transfer from 0
        run_req(2, 2, 3, 32'hDEAD, 0, 0, "R9");   // non-owner write-back ignored
        run_req(2, 1, 3, 32'hBEEF, 0, 0, "R8");   // owner write-back
        run_req(0, 3, 3, 0, 0, 0, "R8");          // proves Uncached with BEEF
        run_req(2, 3, 3, 32'h5555, 0, 0, "R9");   // write-back to Shared ignored
        run_req(0, 0, 3, 0, 0, 0, "R9");          // data still BEEF
        run_req(1, 2, 7, 0, 0, 0, "R3");          // Uncached write miss
        // R9: stray owner data while idle is ignored
        @(negedge clk); owner_wb_valid = 1'b1; owner_wb_data = 32'hFFFF;
        @(negedge clk); owner_wb_valid = 1'b0;
        chk(msg_valid == 1'b0 && req_ready == 1'b1, "R9", "stray owner data",
            int'({msg_valid, req_ready}), 1);
        run_req(0, 1, 7, 0, 2, 32'h77, "R6");     // fetch to owner 2
        run_req(0, 1, 9, 0, 0, 0, "R2");
        run_req(1, 1, 9, 0, 0, 0, "R5");          // sole sharer: no invalidations
        run_req(0, 0, 9, 0, 4, 32'h99, "R6");     // fetch to owner 1
        run_req(1, 3, 9, 0, 0, 0, "R5");          // invalidate 0 and 1

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule